// File: doc/BRIEF.md
# Debug Shadow Register Scan Chain

This block is the target-side half of a serial debug link to a small CPU. The CPU has four 8-bit general registers, an 8-bit program counter and a 16-bit instruction word. Beside it sits a 64-bit chain of shadow registers. A debug host shifts the chain through a serial data input and a serial data output, using a serial clock that it drives itself. The CPU's own clock is also asynchronous to the block. Both clocks and the serial data input are sampled by a fast system clock through two-flop synchronizers, and all state changes on that clock.

A falling edge of the CPU clock arms a one-shot snapshot. On the next rising serial-clock edge, the chain captures every CPU register in one step instead of shifting. The host then scans the snapshot out while it scans new shadow contents in. The top byte of the chain is a control byte, and it survives a snapshot. One of its bits tells the CPU's instruction decoder to decode the shadow instruction word in place of the real one. Another bit gates off the decoder's load-enables so that the real instruction register is filled from the shadow word.

The serial pins carry a bit stream paced only by the host's serial clock. There is no valid/ready handshake and no back-pressure. The host must hold each data bit stable for at least three system clock cycles before it raises the serial clock. Host clock phases must likewise each last at least three system clock cycles.

Top module: `dbg_shadow_scan`

## Requirements
- R1: While reset is asserted, and after it is released until the first serial event, the chain is all zero. `miso_out`, `dec_use_shadow`, `dec_gate_loads` and `shadow_ir` are all 0.
- R2: On a synchronized rising edge of `sclk_in` with no snapshot armed, the chain shifts one place toward bit 63. The synchronized `mosi_in` enters at bit 0. A 64-bit scan therefore returns the previous contents, most significant bit first, and leaves the scanned-in vector in the chain.
- R3: Chain layout, where the position is fixed by the snapshot: bits 63:56 control, 55:48 R0, 47:40 R1, 39:32 R2, 31:24 R3, 23:16 PC, 15:8 IR high, 7:0 IR low. On `cpu_gpr`, R0 is bits 31:24 and R3 is bits 7:0.
- R4: A synchronized falling edge of `cpu_clk_in` arms a snapshot. On the next synchronized rising `sclk_in` edge, bits 55:0 load `{cpu_gpr, cpu_pc, cpu_ir}` and no shift takes place. The control byte holds its value.
- R5: The armed snapshot is dropped on the first synchronized falling `sclk_in` edge after the load. Later rising edges shift again.
- R6: Several CPU falling edges before a serial edge still give exactly one load. A rising CPU edge alone arms nothing.
- R7: `dec_use_shadow` equals control bit 1. `shadow_ir` always shows chain bits 15:0. Both change only on a rising serial event.
- R8: `dec_gate_loads` equals control bit 2. A control byte of 0x06 asserts it together with `dec_use_shadow`. A control byte of 0x00 clears both.
- R9: An input change driven between system edges first alters the chain on the third rising system edge after it.
- R10: `miso_out` always presents chain bit 63, so the host reads the first bit before its first rising serial edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Host serial clock (asynchronous) |
| mosi_in | input | 1 | Host serial data into chain bit 0 |
| miso_out | output | 1 | Chain bit 63 to the host |
| cpu_clk_in | input | 1 | CPU clock (asynchronous); its falling edge arms a snapshot |
| cpu_gpr | input | 32 | General registers R0 (31:24) to R3 (7:0) |
| cpu_pc | input | 8 | Program counter |
| cpu_ir | input | 16 | Real instruction register |
| dec_use_shadow | output | 1 | Decoder selects the shadow instruction word |
| dec_gate_loads | output | 1 | Decoder load-enables gated off; IR loads from shadow |
| shadow_ir | output | 16 | Shadow instruction word for the decoder and IR |

## Verification
The bench scans the chain repeatedly. It checks that each scan returns exactly what the previous scan or snapshot left behind. A design with the wrong shift direction or byte layout would return bit-reversed or byte-swapped vectors. A snapshot that also overwrote the control byte would lose the mode the host had set. A design that kept the load armed past the falling serial edge would recapture the registers on every shift, and the scan would come back as garbage. If a lone rising CPU edge or a second falling CPU edge armed an extra load, the result would be a double capture or a capture at the wrong time. The bench also counts the system cycles from a serial-clock change to the output change, which exposes a missing or extra synchronizer stage.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_GPR = 4;
  localparam int unsigned IR_W    = 16;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned SNAP_W  = (NUM_GPR + 1) * REG_W + IR_W;
  localparam int unsigned CHAIN_W = CTRL_W + SNAP_W;
  localparam int unsigned CTRL_SEL_BIT  = 1;
  localparam int unsigned CTRL_GATE_BIT = 2;

  typedef struct packed {
    logic [CTRL_W-1:0]        ctrl;
    logic [NUM_GPR*REG_W-1:0] gpr;
    logic [REG_W-1:0]         pc;
    logic [IR_W-1:0]          ir;
  } chain_t;
endpackage

// File: rtl/dss_sync_edge.sv
module dss_sync_edge #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0][STAGES:0] pipe;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= '0;
      else        pipe[g] <= {pipe[g][STAGES-1:0], async_in[g]};
    end
    assign lvl[g]  = pipe[g][STAGES-1];
    assign rise[g] = pipe[g][STAGES-1] & ~pipe[g][STAGES];
    assign fall[g] = ~pipe[g][STAGES-1] & pipe[g][STAGES];
  end
endmodule

// File: rtl/dss_load_arm.sv
module dss_load_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_evt,
  input  logic step_rise,
  input  logic step_fall,
  output logic load_en,
  output logic loaded
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_en <= 1'b0;
      loaded  <= 1'b0;
    end else if (arm_evt) begin
      load_en <= 1'b1;
      loaded  <= 1'b0;
    end else if (step_rise && load_en) begin
      loaded  <= 1'b1;
    end else if (step_fall && loaded) begin
      load_en <= 1'b0;
      loaded  <= 1'b0;
    end
  end
endmodule

// File: rtl/dss_chain.sv
module dss_chain
  import dss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load_en,
  input  logic              ser_in,
  input  logic [SNAP_W-1:0] snap,
  output chain_t            q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (step) begin
      if (load_en) q <= {q.ctrl, snap};
      else         q <= {q[CHAIN_W-2:0], ser_in};
    end
  end
endmodule

// File: rtl/dbg_shadow_scan.sv
module dbg_shadow_scan
  import dss_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_in,
  input  logic                     mosi_in,
  output logic                     miso_out,
  input  logic                     cpu_clk_in,
  input  logic [NUM_GPR*REG_W-1:0] cpu_gpr,
  input  logic [REG_W-1:0]         cpu_pc,
  input  logic [IR_W-1:0]          cpu_ir,
  output logic                     dec_use_shadow,
  output logic                     dec_gate_loads,
  output logic [IR_W-1:0]          shadow_ir
);
  localparam int unsigned N_SYNC = 3;

  logic [N_SYNC-1:0] s_lvl, s_rise, s_fall;
  logic   mosi_s, sclk_rise, sclk_fall, cpu_fall;
  logic   load_en, loaded;
  chain_t chain;
  logic   sync_unused;

  dss_sync_edge #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({cpu_clk_in, sclk_in, mosi_in}),
    .lvl      (s_lvl),
    .rise     (s_rise),
    .fall     (s_fall)
  );

  assign mosi_s    = s_lvl[0];
  assign sclk_rise = s_rise[1];
  assign sclk_fall = s_fall[1];
  assign cpu_fall  = s_fall[2];
  assign sync_unused = &{1'b0, s_lvl[2:1], s_rise[2], s_rise[0], s_fall[0]};

  dss_load_arm u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_evt   (cpu_fall),
    .step_rise (sclk_rise),
    .step_fall (sclk_fall),
    .load_en   (load_en),
    .loaded    (loaded)
  );

  dss_chain u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (sclk_rise),
    .load_en (load_en),
    .ser_in  (mosi_s),
    .snap    ({cpu_gpr, cpu_pc, cpu_ir}),
    .q       (chain)
  );

  assign miso_out       = chain[CHAIN_W-1];
  assign dec_use_shadow = chain.ctrl[CTRL_SEL_BIT];
  assign dec_gate_loads = chain.ctrl[CTRL_GATE_BIT];
  assign shadow_ir      = chain.ir;
endmodule

// File: rtl/dss_chk.sv
module dss_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        miso_out,
  input logic        sclk_rise,
  input logic        sclk_fall,
  input logic        cpu_fall,
  input logic        load_en,
  input logic        loaded,
  input logic [63:0] chain,
  input logic [31:0] cpu_gpr,
  input logic [7:0]  cpu_pc,
  input logic [15:0] cpu_ir,
  input logic        dec_use_shadow,
  input logic        dec_gate_loads,
  input logic [15:0] shadow_ir
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!miso_out && !dec_use_shadow && !dec_gate_loads && shadow_ir == 16'h0); // R1
    end
  end

  AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !load_en) |=> (miso_out == $past(chain[62]))); // R2

  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && load_en) |=> (chain[55:0] == $past({cpu_gpr, cpu_pc, cpu_ir}))); // R4

  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && load_en) |=> $stable(chain[63:56])); // R4

  AST_ARM_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_fall |=> load_en); // R4

  AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && loaded && !cpu_fall) |=> !load_en); // R5

  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> ($stable(dec_use_shadow) && $stable(dec_gate_loads) && $stable(shadow_ir))); // R7
endmodule

bind dbg_shadow_scan dss_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .miso_out       (miso_out),
  .sclk_rise      (sclk_rise),
  .sclk_fall      (sclk_fall),
  .cpu_fall       (cpu_fall),
  .load_en        (load_en),
  .loaded         (loaded),
  .chain          (chain),
  .cpu_gpr        (cpu_gpr),
  .cpu_pc         (cpu_pc),
  .cpu_ir         (cpu_ir),
  .dec_use_shadow (dec_use_shadow),
  .dec_gate_loads (dec_gate_loads),
  .shadow_ir      (shadow_ir)
);

// File: tb/tb_dbg_shadow_scan.sv
`timescale 1ns/1ps
module tb_dbg_shadow_scan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_in = 1'b0, mosi_in = 1'b0, cpu_clk_in = 1'b0;
  logic [31:0] cpu_gpr = 32'hA1B2C3D4;
  logic [7:0]  cpu_pc  = 8'h5E;
  logic [15:0] cpu_ir  = 16'h7F60;
  logic miso_out, dec_use_shadow, dec_gate_loads;
  logic [15:0] shadow_ir;

  int checks = 0, failures = 0, cyc = 0;
  logic [63:0] rx;

  always #2 clk = ~clk;

  dbg_shadow_scan dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .mosi_in(mosi_in),
    .miso_out(miso_out), .cpu_clk_in(cpu_clk_in), .cpu_gpr(cpu_gpr),
    .cpu_pc(cpu_pc), .cpu_ir(cpu_ir), .dec_use_shadow(dec_use_shadow),
    .dec_gate_loads(dec_gate_loads), .shadow_ir(shadow_ir)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference: input history per system edge, 64-bit vector, arm flags.
  bit [3:0]    hs, hc, hm;
  logic [63:0] m_chain;
  bit          m_arm, m_ld;
  always @(posedge clk) begin
    if (!rst_n) begin
      hs = 0; hc = 0; hm = 0; m_chain = 0; m_arm = 0; m_ld = 0;
    end else begin
      bit rs, fs, cf;
      hs = {hs[2:0], sclk_in};
      hc = {hc[2:0], cpu_clk_in};
      hm = {hm[2:0], mosi_in};
      rs = hs[2] && !hs[3];
      fs = !hs[2] && hs[3];
      cf = !hc[2] && hc[3];
      if (rs) m_chain = m_arm ? {m_chain[63:56], cpu_gpr, cpu_pc, cpu_ir}
                              : {m_chain[62:0], hm[2]};
      if (cf) begin m_arm = 1; m_ld = 0; end
      else if (rs && m_arm) m_ld = 1;
      else if (fs && m_ld) begin m_arm = 0; m_ld = 0; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 miso", {63'b0, miso_out}, {63'b0, m_chain[63]});
      chk("R7 sel", {63'b0, dec_use_shadow}, {63'b0, m_chain[57]});
      chk("R8 gate", {63'b0, dec_gate_loads}, {63'b0, m_chain[58]});
      chk("R7 shadow_ir", {48'b0, shadow_ir}, {48'b0, m_chain[15:0]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk(input logic b);
    mosi_in = b; wait_n(4);
    sclk_in = 1'b1; wait_n(4);
    sclk_in = 1'b0;
  endtask

  task automatic pulse_cpu();
    cpu_clk_in = 1'b1; wait_n(4);
    cpu_clk_in = 1'b0; wait_n(4);
  endtask

  task automatic scan(input logic [63:0] tx, output logic [63:0] got);
    for (int i = 63; i >= 0; i--) begin
      mosi_in = tx[i]; wait_n(4);
      got[i] = miso_out;
      sclk_in = 1'b1; wait_n(4);
      sclk_in = 1'b0;
    end
    wait_n(4);
  endtask

  initial begin
    logic [63:0] t1, t2, t3, t4, t5, t6;
    t1 = {8'h02, 56'h123456789ABCDE};
    t2 = {8'h06, 56'hF0E1D2C3B4A596};
    t3 = {8'h81, 56'h0};
    t4 = {8'h00, 56'h0F1E2D3C4B5A69};
    t5 = {8'h02, 56'h55AA55AA55AA55};
    t6 = 64'h0;
    wait_n(5);
    chk("R1 miso", {63'b0, miso_out}, 64'h0);
    chk("R1 modes", {62'b0, dec_gate_loads, dec_use_shadow}, 64'h0);
    chk("R1 shadow_ir", {48'b0, shadow_ir}, 64'h0);
    rst_n = 1'b1;
    wait_n(3);

    scan(t1, rx);
    chk("R2 first scan returns zero", rx, 64'h0);
    chk("R7 select from 0x02", {62'b0, dec_gate_loads, dec_use_shadow}, 64'h1);
    chk("R7 shadow_ir", {48'b0, shadow_ir}, 64'hBCDE);

    scan(t2, rx);
    chk("R2 scan returns previous", rx, t1);
    chk("R8 0x06 both", {62'b0, dec_gate_loads, dec_use_shadow}, 64'h3);
    chk("R7 shadow_ir", {48'b0, shadow_ir}, 64'hA596);

    pulse_cpu();
    pulse_sclk(1'b1);
    wait_n(4);
    scan(t3, rx);
    chk("R3 R4 snapshot layout, ctrl held", rx, {8'h06, 32'hA1B2C3D4, 8'h5E, 16'h7F60});

    mosi_in = 1'b0; wait_n(4);
    sclk_in = 1'b1;
    wait_n(2);
    chk("R9 two edges, no change", {63'b0, miso_out}, 64'h1);
    wait_n(1);
    chk("R9 third edge, shifted", {63'b0, miso_out}, 64'h0);
    wait_n(2);
    sclk_in = 1'b0; wait_n(4);
    scan(t4, rx);
    chk("R2 R5 single shift", rx, {t3[62:0], 1'b0});
    chk("R8 0x00 clears", {62'b0, dec_gate_loads, dec_use_shadow}, 64'h0);

    cpu_clk_in = 1'b1; wait_n(4);
    pulse_sclk(1'b1);
    wait_n(4);
    scan(t5, rx);
    chk("R6 rising cpu edge arms nothing", rx, {t4[62:0], 1'b1});

    cpu_gpr = 32'h11223344; cpu_pc = 8'h99; cpu_ir = 16'hBEEF;
    cpu_clk_in = 1'b0; wait_n(4);
    pulse_cpu();
    pulse_sclk(1'b0);
    wait_n(4);
    scan(t6, rx);
    chk("R6 R4 double arm, one load", rx, {8'h02, 32'h11223344, 8'h99, 16'hBEEF});
    chk("R5 shifts after disarm", {63'b0, miso_out}, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule